// File: doc/BRIEF.md
# Packed Fixed-Point Multiply-Accumulate Unit

This block is a two-stage pipelined packed multiplier for vector operands of up to 128 bits. Each cycle it can accept two operand vectors and one of two operation kinds. The first kind, `OP_Q15`, treats every 16-bit word lane as a signed fraction and returns the rounded high half of each lane product. The second kind, `OP_PAIR`, multiplies unsigned bytes of the first operand by signed bytes of the second. It adds each adjacent pair of products and clamps the sum to a signed 16-bit word.

A width select limits the operation to the low 64 bits. In that case the upper word lanes of the result are forced to zero. The pipeline has no backpressure. A valid bit travels with the data through stage S1 (products registered) and stage S2 (result rounded or saturated, then registered). The operation kind rides along as an enumerated tag and selects the S2 path. The only transitions are S1 capture on `in_valid` and S2 capture on the S1 valid bit. When no valid data reaches S2, the output vector holds its last value.

Top module: `pkmac_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `out_vec` is all zeros.
- R2: An operation accepted with `in_valid` high at clock edge k appears on `out_vec` with `out_valid` high after clock edge k+2. Back-to-back operations are accepted on every cycle.
- R3: With `op_sel`=0 (Q15), each word lane k (bits 16k+15..16k) yields the low 16 bits of ((a·b >>> 14) + 1) >>> 1, where a and b are signed. For example, 0x4000·0x4000 gives 0x2000, 0xA000·0x4000 gives 0xD000, and 0x0001·0x4000 gives 0x0001.
- R4: In Q15 mode, 0x8000·0x8000 yields 0x8000 (the result wraps and is not saturated).
- R5: With `op_sel`=1 (pair mode), word k equals a[2k]·b[2k] + a[2k+1]·b[2k+1]. Byte j occupies bits 8j+7..8j, the `opa` bytes are unsigned and the `opb` bytes are signed. An in-range sum is passed through unchanged.
- R6: In pair mode, a sum above 32767 is output as 0x7FFF.
- R7: In pair mode, a sum below -32768 is output as 0x8000.
- R8: With `wide_sel`=0, bits 127..64 of the result are zero whatever the upper operand bits are. With `wide_sel`=1, all eight lanes are computed.
- R9: When `out_valid` is low, `out_vec` keeps its previous value. Operands presented with `in_valid` low have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op_sel | input | 1 | 0 = Q15 rounded multiply, 1 = byte pair sum |
| wide_sel | input | 1 | 1 = 128-bit operation, 0 = low 64 bits only |
| opa | input | VEC_BITS | First operand vector (unsigned bytes in pair mode) |
| opb | input | VEC_BITS | Second operand vector (signed bytes in pair mode) |
| out_valid | output | 1 | Result on `out_vec` is new this cycle |
| out_vec | output | VEC_BITS | Packed 16-bit result words |

## Verification
The bench builds the unit with the default `VEC_BITS` of 128. At that size both the four-lane narrow mode and the eight-lane wide mode can be reached, so the masking of the upper half is visible next to fully computed lanes. At the same width, directed vectors reach the Q15 wrap case, the rounding of tiny positive and negative products, and both saturation limits of the pair sum. Random back-to-back traffic with gaps then exercises the valid pipeline and the output hold.

// File: rtl/pkmac_pkg.sv
package pkmac_pkg;

    localparam int LANE_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic {
        OP_Q15  = 1'b0,
        OP_PAIR = 1'b1
    } op_kind_t;

    typedef struct packed {
        logic signed [31:0] prod;
        logic signed [16:0] p_even;
        logic signed [16:0] p_odd;
    } lane_prod_t;

endpackage

// File: rtl/pkmac_mul_lane.sv
module pkmac_mul_lane
    import pkmac_pkg::*;
(
    input  logic [LANE_W-1:0] a_word,
    input  logic [LANE_W-1:0] b_word,
    output lane_prod_t        prods
);

    logic [BYTE_W-1:0] a_lo, a_hi;
    logic [BYTE_W-1:0] b_lo, b_hi;

    always_comb begin
        a_lo = a_word[BYTE_W-1:0];
        a_hi = a_word[LANE_W-1:BYTE_W];
        b_lo = b_word[BYTE_W-1:0];
        b_hi = b_word[LANE_W-1:BYTE_W];
        prods.prod   = $signed(a_word) * $signed(b_word);
        prods.p_even = $signed({1'b0, a_lo}) * $signed(b_lo);
        prods.p_odd  = $signed({1'b0, a_hi}) * $signed(b_hi);
    end

endmodule

// File: rtl/pkmac_post_lane.sv
module pkmac_post_lane
    import pkmac_pkg::*;
(
    input  op_kind_t          op,
    input  lane_prod_t        prods,
    output logic [LANE_W-1:0] res
);

    localparam logic signed [17:0] SAT_HI = 18'sd32767;
    localparam logic signed [17:0] SAT_LO = -18'sd32768;

    logic signed [17:0] pair_sum;

    always_comb begin
        pair_sum = $signed({prods.p_even[16], prods.p_even})
                 + $signed({prods.p_odd[16], prods.p_odd});
        res = '0;
        unique case (op)
            OP_Q15: begin
                res = 16'(((prods.prod >>> 14) + 32'sd1) >>> 1);
            end
            OP_PAIR: begin
                if (pair_sum > SAT_HI)
                    res = 16'h7FFF;
                else if (pair_sum < SAT_LO)
                    res = 16'h8000;
                else
                    res = pair_sum[15:0];
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/pkmac_unit.sv
module pkmac_unit
    import pkmac_pkg::*;
#(
    parameter int VEC_BITS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                op_sel,
    input  logic                wide_sel,
    input  logic [VEC_BITS-1:0] opa,
    input  logic [VEC_BITS-1:0] opb,
    output logic                out_valid,
    output logic [VEC_BITS-1:0] out_vec
);

    localparam int NUM_LANES    = VEC_BITS / LANE_W;
    localparam int NARROW_LANES = NUM_LANES / 2;
    localparam int HALF_BITS    = NARROW_LANES * LANE_W;

    logic          s1_valid;
    op_kind_t      s1_op;
    logic          s1_wide;
    lane_prod_t    s1_prod  [NUM_LANES];
    lane_prod_t    mul_out  [NUM_LANES];
    logic [LANE_W-1:0] post_res [NUM_LANES];
    logic [VEC_BITS-1:0] next_vec;

    for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
        localparam bit IN_LOW_HALF = (gl < NARROW_LANES);

        pkmac_mul_lane u_mul (
            .a_word (opa[gl*LANE_W +: LANE_W]),
            .b_word (opb[gl*LANE_W +: LANE_W]),
            .prods  (mul_out[gl])
        );

        pkmac_post_lane u_post (
            .op    (s1_op),
            .prods (s1_prod[gl]),
            .res   (post_res[gl])
        );

        assign next_vec[gl*LANE_W +: LANE_W] =
            (s1_wide || IN_LOW_HALF) ? post_res[gl] : '0;

        if (IN_LOW_HALF) begin : g_q15_chk
            AST_Q15_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (s1_valid && s1_op == OP_Q15) |=>
                ((out_vec[gl*LANE_W +: LANE_W] - $past(s1_prod[gl].prod[30:15])) <= 16'd1)); // R3
        end
    end

    // Stage S1: capture products, operation tag and width
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_Q15;
            s1_wide  <= 1'b0;
            for (int i = 0; i < NUM_LANES; i++) s1_prod[i] <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_op   <= op_kind_t'(op_sel);
                s1_wide <= wide_sel;
                for (int i = 0; i < NUM_LANES; i++) s1_prod[i] <= mul_out[i];
            end
        end
    end

    // Stage S2: register the finished words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_vec <= next_vec;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R2

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(wide_sel, 2)) |-> (out_vec[VEC_BITS-1:HALF_BITS] == '0)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_vec)); // R9

endmodule

// File: tb/pkmac_unit_tb_top.sv
`timescale 1ns/1ps
module pkmac_unit_tb_top;

    localparam int VB = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          op_sel = 1'b0;
    logic          wide_sel = 1'b1;
    logic [VB-1:0] opa = '0;
    logic [VB-1:0] opb = '0;
    logic          out_valid;
    logic [VB-1:0] out_vec;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    bit    cmp_on   = 1'b0;
    string phase    = "R1";

    always #10 clk = ~clk;

    pkmac_unit #(.VEC_BITS(VB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .wide_sel(wide_sel), .opa(opa), .opb(opb),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [VB-1:0] ref_vec(input logic op, input logic wide,
                                              input logic [VB-1:0] a, input logic [VB-1:0] b);
        logic [VB-1:0] r;
        integer p, q, s, ua, sb;
        r = '0;
        for (int k = 0; k < VB/16; k++) begin
            if (wide || k < VB/32) begin
                if (!op) begin
                    p = $signed(a[16*k +: 16]) * $signed(b[16*k +: 16]);
                    q = ((p >>> 14) + 1) >>> 1;
                    r[16*k +: 16] = q[15:0];
                end else begin
                    s = 0;
                    for (int j = 0; j < 2; j++) begin
                        ua = a[16*k + 8*j +: 8];
                        sb = $signed(b[16*k + 8*j +: 8]);
                        s = s + ua * sb;
                    end
                    if (s > 32767) s = 32767;
                    if (s < -32768) s = -32768;
                    r[16*k +: 16] = s[15:0];
                end
            end
        end
        return r;
    endfunction

    // Behavioural cycle model
    logic          m1_v, m_v;
    logic [VB-1:0] m1_vec, m_vec;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_v <= 1'b0; m_v <= 1'b0; m1_vec <= '0; m_vec <= '0;
        end else begin
            m_v <= m1_v;
            if (m1_v) m_vec <= m1_vec;
            m1_v <= in_valid;
            if (in_valid) m1_vec <= ref_vec(op_sel, wide_sel, opa, opb);
        end
    end

    task automatic check(input string tag, input logic [VB-1:0] act, input logic [VB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cmp_on && rst_n) begin
            check({phase, " out_valid"}, VB'(out_valid), VB'(m_v));
            check({phase, " out_vec"}, out_vec, m_vec);
        end
    end

    task automatic send(input logic op, input logic wide,
                        input logic [VB-1:0] a, input logic [VB-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; wide_sel = wide; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 not yet valid", VB'(out_valid), VB'(0));
        @(negedge clk);
        check("R2 valid after two edges", VB'(out_valid), VB'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", VB'(out_valid), VB'(0));
        check("R1 reset out_vec", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle after reset", out_vec, '0);
        cmp_on = 1'b1;

        phase = "R3";
        send(1'b0, 1'b1, {64'h0, 16'hFFFF, 16'h0001, 16'hA000, 16'h4000},
                         {64'h0, 16'h4000, 16'h4000, 16'h4000, 16'h4000});
        check("R3 q15 lanes", out_vec, {64'h0, 16'h0000, 16'h0001, 16'hD000, 16'h2000});

        phase = "R4";
        send(1'b0, 1'b1, {8{16'h8000}}, {8{16'h8000}});
        check("R4 wrap", out_vec, {8{16'h8000}});

        phase = "R5";
        send(1'b1, 1'b1, {{7{16'h0000}}, 16'h03FF}, {{7{16'h0000}}, 16'h02FE});
        check("R5 pair sum", out_vec, {{7{16'h0000}}, 16'hFE08});

        phase = "R6";
        send(1'b1, 1'b1, {8{16'hFFFF}}, {8{16'h7F7F}});
        check("R6 saturate high", out_vec, {8{16'h7FFF}});

        phase = "R7";
        send(1'b1, 1'b1, {8{16'hFFFF}}, {8{16'h8080}});
        check("R7 saturate low", out_vec, {8{16'h8000}});

        phase = "R8";
        send(1'b0, 1'b0, {8{16'h4000}}, {8{16'h4000}});
        check("R8 narrow upper zero", out_vec, {64'h0, {4{16'h2000}}});

        phase = "R9";
        @(negedge clk);
        in_valid = 1'b0; opa = {8{16'h1234}}; opb = {8{16'h7777}}; op_sel = 1'b1; wide_sel = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 hold when idle", out_vec, {64'h0, {4{16'h2000}}});

        phase = "R2";
        for (int n = 0; n < 400; n++) begin
            in_valid = ($urandom_range(3) != 0);
            op_sel   = $urandom_range(1);
            wide_sel = $urandom_range(1);
            for (int w = 0; w < VB/32; w++) begin
                opa[32*w +: 32] = $urandom;
                opb[32*w +: 32] = $urandom;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule